// File: doc/BRIEF.md
# Byte-Pair to Word Capture Interface

This receiver sits on the host side of a converter link that delivers each 16-bit sample as two bytes on one 8-bit bus, framed by a single strobe: the first byte is valid on the strobe's rising edge and the second on its falling edge. The strobe, the byte bus and a clip flag all arrive without any relation to the system clock. They pass through a synchroniser, and both strobe edges are detected in the system clock domain. The receiver then rebuilds the word, latches the clip flag with whichever edge carries the high byte, and emits a one-cycle valid pulse when a word is complete.

A configuration pin selects whether the high or the low byte comes first. A second pin selects synchronous update, in which the first byte is held aside and all 16 output bits change in the same cycle. Without synchronous update, the first byte's half of the word changes as soon as it is captured. An output-enable pin forces the word outputs to zero, in place of a three-state driver.

The output stream is valid-only. The converter cannot be paused, so there is no ready input and no back-pressure. A consumer must accept each word in the cycle in which `word_valid_o` is high. The word stays on `word_o` until the next capture, so it can also be read at any later time.

Top module: `bytepair_word_rx`

## Requirements
- R1: After reset `word_o` is 0, `clip_o` is 0, `word_valid_o` is 0 and `frame_err_o` is 0.
- R2: The strobe passes through a 2-flop synchroniser and a registered edge detector. `word_valid_o` rises after the 4th rising clock edge that follows a strobe fall placed on the input, and not before.
- R3: With `hi_first_i`=1 the byte captured at the strobe rise goes to `word_o[15:8]` and the byte at the fall goes to `word_o[7:0]`. With `hi_first_i`=0 the byte at the rise goes to `word_o[7:0]` and the byte at the fall goes to `word_o[15:8]`.
- R4: `clip_o` takes the value of `clip_i` at the strobe edge that frames the high byte: the rise when `hi_first_i`=1, the fall when it is 0. A clip value present only at the other edge has no effect on `clip_o`.
- R5: Each completed pair (a rise followed by a fall) gives exactly one `word_valid_o` pulse, one cycle wide, in the cycle in which the new word appears on `word_o`.
- R6: With `sync_upd_i`=1, `word_o` does not change between the strobe rise and the fall. All 16 bits change together in the cycle of the valid pulse.
- R7: With `sync_upd_i`=0, the half of `word_o` that the first byte belongs to is updated after the rise, before the fall. The other half keeps its previous value until the fall.
- R8: A strobe fall with no captured rise before it gives no valid pulse and leaves `word_o` unchanged. It sets `frame_err_o`, which stays at 1 until reset. A strobe that is already high when reset is released is learned as the idle level, not taken as a rise.
- R9: With `oe_i`=0, `word_o` reads 0. Capture and valid pulses go on as before, and the captured word reappears when `oe_i` returns to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| strb_i | input | 1 | Asynchronous byte strobe from the converter |
| data_i | input | 8 | Asynchronous byte bus |
| clip_i | input | 1 | Asynchronous clip flag, valid with the high byte |
| hi_first_i | input | 1 | 1: high byte arrives at the rise; 0: low byte arrives at the rise |
| sync_upd_i | input | 1 | 1: all 16 output bits update together |
| oe_i | input | 1 | Output enable; 0 forces `word_o` to zero |
| word_o | output | 16 | Assembled word |
| clip_o | output | 1 | Clip flag of the last high byte |
| word_valid_o | output | 1 | One-cycle pulse when a new word is on `word_o` |
| frame_err_o | output | 1 | Sticky flag for a strobe fall with no preceding rise |

## Verification
The assertions take for granted that the byte bus and the clip flag are steady for at least two clocks before each strobe edge and for several clocks after it. They also assume that each strobe level lasts longer than the synchroniser depth plus two clocks, and that `hi_first_i` and `sync_upd_i` are not changed in the middle of a pair. The bench changes the data two clocks before each edge and holds every strobe level for ten clocks. It changes configuration only while the strobe is low and the previous pair is complete.

// File: rtl/bpw_pkg.sv
package bpw_pkg;
  // Strobe edge events, one cycle each, in the system clock domain.
  typedef struct packed {
    logic rise;
    logic fall;
  } edge_ev_t;
endpackage

// File: rtl/bpw_sync.sv
module bpw_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[s] <= '0;
          else        stg[s] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[s] <= '0;
          else        stg[s] <= stg[s-1];
        end
      end
    end
  endgenerate

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/bpw_edge.sv
module bpw_edge
  import bpw_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     lvl_i,
  output edge_ev_t ev_o
);
  // Hold off edge detection until the synchroniser output reflects the pin.
  localparam int LIM = STAGES + 1;
  localparam int CW  = $clog2(LIM + 1);
  localparam logic [CW-1:0] LIM_C = CW'(LIM);

  logic          prev_q;
  logic [CW-1:0] warm_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      warm_q <= '0;
      ev_o   <= '0;
    end else begin
      prev_q <= lvl_i;
      if (warm_q != LIM_C) begin
        warm_q <= warm_q + 1'b1;
        ev_o   <= '0;
      end else begin
        ev_o.rise <= lvl_i & ~prev_q;
        ev_o.fall <= ~lvl_i & prev_q;
      end
    end
  end

  // R2: consecutive events are at least two cycles apart.
  assert_edge_spacing_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_o.rise || ev_o.fall) |=> !(ev_o.rise || ev_o.fall));
endmodule

// File: rtl/bpw_capture.sv
module bpw_capture
  import bpw_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  edge_ev_t            ev_i,
  input  logic [BYTE_W-1:0]   byte_i,
  input  logic                clip_i,
  input  logic                hi_first_i,
  input  logic                sync_upd_i,
  output logic [2*BYTE_W-1:0] word_o,
  output logic                clip_o,
  output logic                valid_o,
  output logic                frame_err_o
);
  localparam int WORD_W = 2 * BYTE_W;

  logic [BYTE_W-1:0] first_q;
  logic              armed_q;
  logic [WORD_W-1:0] full_w;
  logic              pair_done;
  logic              hb_event;

  assign full_w    = hi_first_i ? {first_q, byte_i} : {byte_i, first_q};
  assign pair_done = ev_i.fall & armed_q;
  assign hb_event  = (ev_i.rise & hi_first_i) | (pair_done & ~hi_first_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      first_q     <= '0;
      armed_q     <= 1'b0;
      word_o      <= '0;
      clip_o      <= 1'b0;
      valid_o     <= 1'b0;
      frame_err_o <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (hb_event) clip_o <= clip_i;
      if (ev_i.rise) begin
        armed_q <= 1'b1;
        first_q <= byte_i;
        if (!sync_upd_i) begin
          if (hi_first_i) word_o[WORD_W-1:BYTE_W] <= byte_i;
          else            word_o[BYTE_W-1:0]      <= byte_i;
        end
      end
      if (ev_i.fall) begin
        if (armed_q) begin
          armed_q <= 1'b0;
          word_o  <= full_w;
          valid_o <= 1'b1;
        end else begin
          frame_err_o <= 1'b1;
        end
      end
    end
  end

  // R5: the valid strobe is a single cycle wide.
  assert_valid_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o);
  // R5: a valid pulse always follows a framed fall.
  assert_valid_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> $past(ev_i.fall));
  // R6: in synchronous mode the word only moves on pair completion.
  assert_sync_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_upd_i && !pair_done) |=> $stable(word_o));
  // R4: the clip flag only moves with the high byte edge.
  assert_clip_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !hb_event |=> $stable(clip_o));
  // R8: the framing error is sticky.
  assert_ferr_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err_o |=> frame_err_o);
  // R8: an orphan fall never yields a word.
  assert_orphan_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_i.fall && !armed_q) |=> (!valid_o && $stable(word_o)));
endmodule

// File: rtl/bytepair_word_rx.sv
module bytepair_word_rx
  import bpw_pkg::*;
#(
  parameter int BYTE_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                strb_i,
  input  logic [BYTE_W-1:0]   data_i,
  input  logic                clip_i,
  input  logic                hi_first_i,
  input  logic                sync_upd_i,
  input  logic                oe_i,
  output logic [2*BYTE_W-1:0] word_o,
  output logic                clip_o,
  output logic                word_valid_o,
  output logic                frame_err_o
);
  localparam int WORD_W = 2 * BYTE_W;
  localparam int BUS_W  = BYTE_W + 2;

  logic [BUS_W-1:0]  bus_s;
  logic              strb_s;
  logic [BYTE_W-1:0] data_s;
  logic              clip_s;
  edge_ev_t          ev;
  logic [WORD_W-1:0] word_r;

  // Strobe, byte and clip share one synchroniser so they stay aligned.
  bpw_sync #(.W(BUS_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   ({strb_i, clip_i, data_i}),
    .q_o   (bus_s)
  );
  assign {strb_s, clip_s, data_s} = bus_s;

  bpw_edge #(.STAGES(SYNC_STAGES)) u_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .lvl_i (strb_s),
    .ev_o  (ev)
  );

  bpw_capture #(.BYTE_W(BYTE_W)) u_cap (
    .clk         (clk),
    .rst_n       (rst_n),
    .ev_i        (ev),
    .byte_i      (data_s),
    .clip_i      (clip_s),
    .hi_first_i  (hi_first_i),
    .sync_upd_i  (sync_upd_i),
    .word_o      (word_r),
    .clip_o      (clip_o),
    .valid_o     (word_valid_o),
    .frame_err_o (frame_err_o)
  );

  assign word_o = oe_i ? word_r : '0;

  // R9: when re-enabled the held word shows unchanged if nothing was captured.
  assert_oe_restore_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(oe_i) && !word_valid_o && !$past(word_valid_o)) |-> (word_o == $past(word_r)));
endmodule

// File: tb/bytepair_word_rx_tb.sv
module bytepair_word_rx_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WDOG_LIMIT = 20000;

  typedef struct packed {
    logic        hf;
    logic        sm;
    logic [7:0]  b1;
    logic        c1;
    logic [7:0]  b2;
    logic        c2;
    logic [15:0] w;
    logic        c;
  } vec_t;

  // R3/R4 vectors: expected word placement and clip from the high byte edge.
  localparam int NV = 6;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 1'b1, 8'hA5, 1'b0, 8'h3C, 1'b1, 16'hA53C, 1'b0},
    '{1'b0, 1'b1, 8'hA5, 1'b1, 8'h3C, 1'b0, 16'h3CA5, 1'b0},
    '{1'b1, 1'b0, 8'hFF, 1'b1, 8'h00, 1'b0, 16'hFF00, 1'b1},
    '{1'b0, 1'b0, 8'h12, 1'b0, 8'h34, 1'b1, 16'h3412, 1'b1},
    '{1'b1, 1'b0, 8'h00, 1'b0, 8'h01, 1'b0, 16'h0001, 1'b0},
    '{1'b0, 1'b1, 8'h80, 1'b1, 8'h7F, 1'b1, 16'h7F80, 1'b1}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        strb = 1'b0;
  logic [7:0]  data = '0;
  logic        clip = 1'b0;
  logic        hf = 1'b1;
  logic        sm = 1'b0;
  logic        oe = 1'b1;
  logic [15:0] word;
  logic        clip_o, vld, ferr;

  int checks = 0;
  int errors = 0;
  int vcnt = 0;
  int cyc = 0;
  bit done = 0;

  bytepair_word_rx dut_i (
    .clk (clk), .rst_n (rst_n), .strb_i (strb), .data_i (data), .clip_i (clip),
    .hi_first_i (hf), .sync_upd_i (sm), .oe_i (oe),
    .word_o (word), .clip_o (clip_o), .word_valid_o (vld), .frame_err_o (ferr)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) if (vld) vcnt++;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > WDOG_LIMIT) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, WDOG_LIMIT);
      report();
    end
  end

  task automatic first_half(input logic [7:0] b, input logic c);
    data = b; clip = c;
    repeat (2) @(negedge clk);
    strb = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic second_half(input logic [7:0] b, input logic c);
    data = b; clip = c;
    repeat (2) @(negedge clk);
    strb = 1'b0;
    repeat (8) @(negedge clk);
  endtask

  task automatic do_reset(input logic strb_lvl);
    strb = strb_lvl;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  initial begin
    int v0;
    do_reset(1'b0);
    // R1 reset state
    chk(word == 16'h0, "R1 word", word, 0);
    chk(clip_o == 1'b0, "R1 clip", clip_o, 0);
    chk(vld == 1'b0, "R1 valid", vld, 0);
    chk(ferr == 1'b0, "R1 frame_err", ferr, 0);

    // Vector table: R3 placement, R4 clip, R5 one pulse per pair
    for (int i = 0; i < NV; i++) begin
      hf = VEC[i].hf; sm = VEC[i].sm;
      v0 = vcnt;
      first_half(VEC[i].b1, VEC[i].c1);
      second_half(VEC[i].b2, VEC[i].c2);
      chk(word == VEC[i].w, "R3 word", word, VEC[i].w);
      chk(clip_o == VEC[i].c, "R4 clip", clip_o, VEC[i].c);
      chk(vcnt == v0 + 1, "R5 pulse count", vcnt - v0, 1);
    end
    chk(ferr == 1'b0, "R8 no error on framed pairs", ferr, 0);

    // R2 latency and R5 width, sampled each negedge after the fall
    hf = 1'b1; sm = 1'b1;
    first_half(8'h5A, 1'b0);
    data = 8'hC3;
    repeat (2) @(negedge clk);
    strb = 1'b0;
    for (int k = 1; k <= 5; k++) begin
      @(negedge clk);
      if (k < 4)  chk(vld == 1'b0, "R2 early valid", vld, 0);
      if (k == 4) chk(vld == 1'b1 && word == 16'h5AC3, "R2 valid at 4th edge", {vld, word}, {1'b1, 16'h5AC3});
      if (k == 5) chk(vld == 1'b0, "R5 one cycle", vld, 0);
    end
    repeat (4) @(negedge clk);

    // R7 non-synchronous: first half moves early
    sm = 1'b0;
    first_half(8'h11, 1'b0);
    chk(word == 16'h11C3, "R7 early half", word, 16'h11C3);
    second_half(8'h22, 1'b0);
    chk(word == 16'h1122, "R7 complete", word, 16'h1122);

    // R6 synchronous: nothing moves until the fall
    sm = 1'b1;
    first_half(8'h33, 1'b0);
    chk(word == 16'h1122, "R6 held mid-pair", word, 16'h1122);
    second_half(8'h44, 1'b0);
    chk(word == 16'h3344, "R6 complete", word, 16'h3344);

    // R4 clip present only at the non-high edge is ignored
    hf = 1'b1;
    first_half(8'h01, 1'b0);
    second_half(8'h02, 1'b1);
    chk(clip_o == 1'b0, "R4 clip at low edge ignored", clip_o, 0);

    // R9 output enable
    oe = 1'b0;
    @(negedge clk);
    chk(word == 16'h0, "R9 gated", word, 0);
    v0 = vcnt;
    first_half(8'h55, 1'b0);
    second_half(8'h66, 1'b0);
    chk(word == 16'h0 && vcnt == v0 + 1, "R9 gated capture", {vcnt - v0, word}, {32'd1, 16'h0});
    oe = 1'b1;
    @(negedge clk);
    chk(word == 16'h5566, "R9 restored", word, 16'h5566);

    // R8 orphan fall after reset with strobe high
    do_reset(1'b1);
    chk(ferr == 1'b0 && word == 16'h0, "R8 high strobe at reset is idle", {ferr, word}, 0);
    v0 = vcnt;
    strb = 1'b0;
    repeat (8) @(negedge clk);
    chk(ferr == 1'b1, "R8 frame_err set", ferr, 1);
    chk(vcnt == v0 && word == 16'h0, "R8 no word", {vcnt - v0, word}, 0);
    first_half(8'h9A, 1'b0);
    second_half(8'hBC, 1'b0);
    chk(word == 16'h9ABC && ferr == 1'b1, "R8 sticky", {ferr, word}, {1'b1, 16'h9ABC});
    do_reset(1'b0);
    chk(ferr == 1'b0 && word == 16'h0, "R1 reset clears", {ferr, word}, 0);

    report();
  end
endmodule